// File: doc/BRIEF.md
# Rotor-Stall and Clock-Loss Protection Supervisor

This block guards a brushless motor drive stage. It turns off the PWM-side outputs in three cases. The first is a rotor that stays out of speed lock too long while the drive is running. The second is a command clock that stops toggling while the drive is running. The third is a power-on reset request. Everything is timed from the free-running system clock. A prescaler makes a slow tick, and the stall timeout is set as a count of those ticks.

A stall fault latches. Restarting the drive does not release it. It clears only after the drive has been held out of the running state continuously for a fixed clear window of about 1 ms, or when a power-on reset is applied. A clock-loss condition does not latch. It ends on its own as soon as command-clock edges return, provided the stall timer has not expired in the meantime.

The running state means run requested and brake not requested. Brake overrides run, and both brake and stop count as "not running".

Top module: `stall_guard`

## Requirements
- R1: The stall timer advances only in the running state while `lock_ok` is 0. With the drive stopped, or with lock held, no stall fault ever appears, however long the rotor stays unlocked.
- R2: When the stall timer has counted `stall_limit` prescaled ticks in the running state with `lock_ok` low, `stall_flt` goes to 1 and `drive_off` goes to 1. Both stay set after lock returns.
- R3: The stall timer restarts from zero whenever `lock_ok` returns to 1. Two unlocked stretches, each shorter than the timeout, never add up to a fault.
- R4: A latched stall fault clears after CLR_CYCLES consecutive system cycles out of the running state, stop or brake alike. Before that many cycles it is still set.
- R5: The clear count restarts from zero if the running state is re-entered before it completes.
- R6: In the running state, a command clock with no edge for LOSS_CYCLES system cycles sets `drive_off` without setting `stall_flt`.
- R7: When command-clock edges return before the stall timeout, `drive_off` falls again by itself. If the stall fault latched during the clock loss, `drive_off` stays 1 after the clock returns.
- R8: Loss of the command clock outside the running state has no effect. `drive_off` stays 0.
- R9: While `por_req` is 1, `drive_off` is 1 and the stall fault is cleared.
- R10: `drive_off` is registered. It is 1 during `rst`, and it follows the OR of stall fault, clock loss and `por_req` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| por_req | input | 1 | Power-on reset request; forces drive off and clears the fault |
| run_req | input | 1 | 1 requests the running state |
| brake_req | input | 1 | 1 requests brake; overrides `run_req` |
| lock_ok | input | 1 | 1 when motor speed is inside the lock range |
| cmd_clk | input | 1 | Command clock, asynchronous to `clk` |
| stall_limit | input | TW | Stall timeout in prescaled ticks |
| drive_off | output | 1 | 1 disables the PWM-side outputs |
| stall_flt | output | 1 | Latched stall fault |

## Verification
Clock loss and stall expiry can be active in the same stretch of cycles. The bench provokes this by withholding the command clock while the rotor is unlocked, so that loss is declared first and the stall timer then expires underneath it. It then restores the clock with lock regained. The check is that `drive_off` remains 1 with `stall_flt` set. A separate run, where the clock returns with lock held, expects `drive_off` to drop. A second overlap sets the clear window against a brief return to the running state; the bench expects the fault to survive the full window measured from the last exit.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;

  typedef enum logic [1:0] {
    SG_STOP  = 2'd0,
    SG_BRAKE = 2'd1,
    SG_RUN   = 2'd2
  } drv_mode_e;

  // Brake takes precedence over a run request.
  function automatic drv_mode_e sg_decode(input logic run, input logic brk);
    if (brk)      return SG_BRAKE;
    else if (run) return SG_RUN;
    return SG_STOP;
  endfunction

endpackage

// File: rtl/sg_tick_gen.sv
module sg_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      logic          tick_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt    <= '0;
          tick_q <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
          cnt    <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt    <= cnt + 1'b1;
          tick_q <= 1'b0;
        end
      end

      assign tick = tick_q;

      // R1: ticks are isolated pulses, so the timer moves at most once per tick period
      a_r1_tick_isolated: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    end
  endgenerate

endmodule

// File: rtl/sg_clk_watch.sv
module sg_clk_watch #(
  parameter int unsigned SYNC  = 2,
  parameter int unsigned LIMIT = 4000000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run_active,
  input  logic cmd_clk,
  output logic lost
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [SYNC:0] sh;
  logic          cmd_edge;
  logic [CW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], cmd_clk};
  end

  assign cmd_edge = sh[SYNC] ^ sh[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst || clr || !run_active || cmd_edge) gap <= '0;
    else if (gap != CW'(LIMIT))                gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) lost <= 1'b0;
    else            lost <= run_active && !cmd_edge && (gap == CW'(LIMIT));
  end

  // R8: loss is only ever declared while running
  a_r8_loss_needs_run: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> $past(run_active));

  // R7: any command edge ends a loss on the next cycle
  a_r7_edge_recovers: assert property (@(posedge clk) disable iff (rst)
    cmd_edge |=> !lost);

endmodule

// File: rtl/sg_stall_latch.sv
module sg_stall_latch #(
  parameter int unsigned TW         = 16,
  parameter int unsigned CLR_CYCLES = 50000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          por,
  input  logic          run_active,
  input  logic          lock_ok,
  input  logic          tick,
  input  logic [TW-1:0] stall_limit,
  output logic          flt
);

  localparam int unsigned CCW = $clog2(CLR_CYCLES + 1);

  logic [TW-1:0]  st_cnt;
  logic [CCW-1:0] clr_cnt;

  always_ff @(posedge clk) begin
    if (rst || por) begin
      st_cnt  <= '0;
      clr_cnt <= '0;
      flt     <= 1'b0;
    end else begin
      // stall timer: only running, unlocked and not yet faulted
      if (!run_active || lock_ok || flt)   st_cnt <= '0;
      else if (tick && st_cnt != '1)       st_cnt <= st_cnt + 1'b1;

      if (!flt && run_active && !lock_ok && st_cnt >= stall_limit)
        flt <= 1'b1;

      // clear window: consecutive cycles out of the running state
      if (!flt || run_active) begin
        clr_cnt <= '0;
      end else if (clr_cnt == CCW'(CLR_CYCLES - 1)) begin
        clr_cnt <= '0;
        flt     <= 1'b0;
      end else begin
        clr_cnt <= clr_cnt + 1'b1;
      end
    end
  end

  // R2: a fault is only raised out of the running, unlocked condition
  a_r2_set_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(flt) |-> $past(run_active && !lock_ok));

  // R4: a fault only falls after a non-running cycle or a power-on reset
  a_r4_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(flt) |-> ($past(por) || !$past(run_active)));

  // R3: regained lock leaves the timer at zero
  a_r3_lock_zero: assert property (@(posedge clk) disable iff (rst || por)
    lock_ok |=> (st_cnt == '0));

  // R5: the clear window counter stays inside its range
  always_ff @(posedge clk) begin
    if (!rst) a_r5_clr_range: assert (clr_cnt < CCW'(CLR_CYCLES));
  end

endmodule

// File: rtl/stall_guard.sv
module stall_guard
  import stall_guard_pkg::*;
#(
  parameter int unsigned TW              = 16,
  parameter int unsigned PRE_DIV         = 50000,
  parameter int unsigned CLR_CYCLES      = 50000,
  parameter int unsigned SLOW_CMD_CYCLES = 1000000,
  parameter int unsigned LOSS_CYCLES     = 4 * SLOW_CMD_CYCLES,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          por_req,
  input  logic          run_req,
  input  logic          brake_req,
  input  logic          lock_ok,
  input  logic          cmd_clk,
  input  logic [TW-1:0] stall_limit,
  output logic          drive_off,
  output logic          stall_flt
);

  drv_mode_e mode;
  logic      run_active;
  logic      tick;
  logic      clk_lost;

  assign mode       = sg_decode(run_req, brake_req);
  assign run_active = (mode == SG_RUN);

  sg_tick_gen #(.DIV(PRE_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  sg_clk_watch #(.SYNC(SYNC_STAGES), .LIMIT(LOSS_CYCLES)) u_watch (
    .clk        (clk),
    .rst        (rst),
    .clr        (por_req),
    .run_active (run_active),
    .cmd_clk    (cmd_clk),
    .lost       (clk_lost)
  );

  sg_stall_latch #(.TW(TW), .CLR_CYCLES(CLR_CYCLES)) u_stall (
    .clk         (clk),
    .rst         (rst),
    .por         (por_req),
    .run_active  (run_active),
    .lock_ok     (lock_ok),
    .tick        (tick),
    .stall_limit (stall_limit),
    .flt         (stall_flt)
  );

  always_ff @(posedge clk) begin
    if (rst) drive_off <= 1'b1;
    else     drive_off <= por_req | stall_flt | clk_lost;
  end

  // R9: power-on reset request always disables the drive
  a_r9_por_off: assert property (@(posedge clk) disable iff (rst)
    por_req |=> drive_off);

  // R10: a latched fault is reflected on the drive disable
  a_r10_flt_off: assert property (@(posedge clk) disable iff (rst)
    stall_flt |=> drive_off);

  // R6: a declared clock loss disables the drive
  a_r6_loss_off: assert property (@(posedge clk) disable iff (rst)
    clk_lost |=> drive_off);

endmodule

// File: tb/stall_guard_tb.sv
module stall_guard_tb;

  localparam int unsigned TW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          por_req;
  logic          run_req;
  logic          brake_req;
  logic          lock_ok;
  logic          cmd_clk = 1'b0;
  logic [TW-1:0] stall_limit;
  logic          drive_off;
  logic          stall_flt;

  logic cmd_on;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  typedef struct {
    string req;
    bit    off;
    bit    flt;
  } exp_t;

  exp_t sb_q[$];

  always #10 clk = ~clk;

  stall_guard #(
    .TW(TW), .PRE_DIV(4), .CLR_CYCLES(50), .SLOW_CMD_CYCLES(10),
    .LOSS_CYCLES(30), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .por_req(por_req), .run_req(run_req),
    .brake_req(brake_req), .lock_ok(lock_ok), .cmd_clk(cmd_clk),
    .stall_limit(stall_limit), .drive_off(drive_off), .stall_flt(stall_flt)
  );

  // command clock: toggles every 5 system cycles while enabled
  initial begin
    forever begin
      repeat (5) @(posedge clk);
      if (cmd_on) cmd_clk <= ~cmd_clk;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string r, input bit off, input bit flt);
    exp_t e;
    e.req = r; e.off = off; e.flt = flt;
    sb_q.push_back(e);
  endtask

  // monitor: compares queued expectations just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (drive_off !== e.off || stall_flt !== e.flt) begin
          n_fail++;
          $display("FAIL %s: drive_off=%b stall_flt=%b expected drive_off=%b stall_flt=%b",
                   e.req, drive_off, stall_flt, e.off, e.flt);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; por_req = 0; run_req = 0; brake_req = 0; lock_ok = 1;
    cmd_on = 1; stall_limit = 16'd10;
    cyc(2);
    expect_now("R10 reset value", 1, 0);
    rst = 0;
    cyc(3);
    expect_now("R10 idle after reset", 0, 0);

    // R1 and R8: stopped, unlocked, clock absent
    lock_ok = 0; cmd_on = 0;
    cyc(80);
    expect_now("R1 stopped unlocked", 0, 0);
    expect_now("R8 clock loss while stopped", 0, 0);
    cmd_on = 1; lock_ok = 1;
    cyc(10);

    // R1: running with lock held
    run_req = 1;
    cyc(100);
    expect_now("R1 running locked", 0, 0);

    // R3: two short unlocked stretches
    lock_ok = 0; cyc(30);
    lock_ok = 1; cyc(3);
    lock_ok = 0; cyc(30);
    expect_now("R3 timer restart on lock", 0, 0);
    lock_ok = 1; cyc(2);

    // R2: stall timeout
    lock_ok = 0; cyc(60);
    expect_now("R2 stall latched", 1, 1);
    lock_ok = 1; cyc(20);
    expect_now("R2 latched after relock", 1, 1);

    // R5: clear window restarts when running is re-entered
    run_req = 0; cyc(30);
    expect_now("R5 partial stop", 1, 1);
    run_req = 1; cyc(2);
    run_req = 0; cyc(45);
    expect_now("R5 window restarted", 1, 1);
    cyc(10);
    expect_now("R4 cleared after stop window", 0, 0);

    // R4: brake clears too
    run_req = 1; lock_ok = 0; cyc(60);
    expect_now("R2 stall again", 1, 1);
    lock_ok = 1; brake_req = 1; cyc(60);
    expect_now("R4 cleared by brake", 0, 0);
    brake_req = 0; cyc(5);
    expect_now("R4 running after clear", 0, 0);

    // R6 and R7: clock loss and automatic recovery
    cmd_on = 0; cyc(50);
    expect_now("R6 clock loss off", 1, 0);
    cmd_on = 1; cyc(20);
    expect_now("R7 clock returns", 0, 0);

    // R7: stall expires during clock loss
    cmd_on = 0; lock_ok = 0; cyc(70);
    expect_now("R7 loss plus stall", 1, 1);
    cmd_on = 1; lock_ok = 1; cyc(20);
    expect_now("R7 stays off after clock return", 1, 1);

    // R9 and R10: power-on reset clears the fault, one-edge latency
    por_req = 1;
    expect_now("R10 before edge", 1, 1);
    cyc(1);
    expect_now("R9 por active", 1, 0);
    run_req = 0; por_req = 0; cyc(3);
    expect_now("R9 por released", 0, 0);

    por_req = 1;
    expect_now("R10 registered no early change", 0, 0);
    cyc(1);
    expect_now("R10 one edge latency", 1, 0);
    por_req = 0; cyc(2);
    expect_now("R10 released", 0, 0);

    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule